// File: doc/BRIEF.md
# Low-Power State Controller

This block sequences the sleep states of a small 8-bit microcontroller. Software requests either a light sleep (idle) or a deep sleep (power-down) with single-cycle request strobes. In light sleep only the CPU clock is stopped. Timers, the serial port and interrupt logic keep their clock, so any enabled interrupt that becomes pending wakes the core. In deep sleep the oscillator, the CPU clock and the peripheral clocks are all stopped. Only the external reset pin can bring the device back.

The block also filters the raw reset pin. A reset is accepted only after the pin has been seen high on a full count of consecutive clocks while the oscillator is stable. The default count is two machine cycles of twelve clocks each. When waking from deep sleep, the oscillator is restarted and given a settling period before the filter starts counting. While asleep, the block supplies fixed override levels for the address-latch strobe and the program-fetch strobe. It also tells the pad logic whether the multiplexed low address/data port must float, which depends on whether code runs from external memory.

Leaving light sleep through the reset pin restarts the CPU clock at once, before the filtered reset takes over. For that window the block raises a write-block signal for internal RAM. Port writes are deliberately left unblocked.

Top module: `lp_power_ctrl`

## Requirements
- R1: After power-on reset the block is running: CPU, peripheral and oscillator enables are 1; pinOvrEn, aleLevel, psenLevel, p0Float, sysRst and ramWrBlock are 0.
- R2: In the running state, an idleReq sampled high enters idle at that edge, so cpuClkEn=0 while perClkEn=1 and oscEn=1. If idleReq and pdReq are high together, power-down is taken.
- R3: In idle, an irqPending sampled high returns the block to running at that edge. irqPending has no effect in the running state or in power-down.
- R4: In power-down, cpuClkEn, perClkEn and oscEn are all 0. Only a high reset pin sample leaves that state.
- R5: sysRst is 1 exactly when the reset pin has been sampled high on the last CLKS_PER_MC*RST_MCS consecutive clock edges (24 by default) while the oscillator is stable. A single low sample restarts the count and drops sysRst at that edge.
- R6: pinOvrEn is 1 in every sleep state. In idle, aleLevel=1 and psenLevel=1. In power-down and during oscillator restart, both levels are 0. In the running state all three are 0.
- R7: p0Float equals extExec in every sleep state and is 0 in the running state.
- R8: When idle is left because the reset pin is sampled high, cpuClkEn returns to 1 at that edge. From that edge ramWrBlock stays 1 until the reset pin is sampled low.
- R9: A high reset pin sample in power-down sets oscEn=1 at that edge while cpuClkEn and perClkEn stay 0. The reset filter counts only after STAB_CYCLES further clocks. A low pin sample during the restart returns to power-down.
- R10: idleReq and pdReq are ignored while sysRst is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstPin | input | 1 | Raw external reset pin, active high |
| idleReq | input | 1 | Software strobe requesting idle |
| pdReq | input | 1 | Software strobe requesting power-down |
| irqPending | input | 1 | An enabled interrupt is pending |
| extExec | input | 1 | Code is being fetched from external memory |
| cpuClkEn | output | 1 | CPU clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| pinOvrEn | output | 1 | Strobe pins take the override levels below |
| aleLevel | output | 1 | Override level for the address-latch strobe |
| psenLevel | output | 1 | Override level for the program-fetch strobe |
| p0Float | output | 1 | Low address/data port must be released |
| sysRst | output | 1 | Filtered system reset |
| ramWrBlock | output | 1 | Internal RAM writes are blocked |

## Verification
The bench targets the boundaries of the reset filter. A pin that drops one clock before the full count must yield no reset. A reset that fires one clock early or late, or one that survives a low sample, would show up as a wrong sysRst edge.

Power-down wake is exercised twice. First it is aborted by a short pin pulse, which must fall back to power-down with the oscillator stopped. Then it completes, and a controller that started filtering before the settling period ended would assert reset too soon.

The bench also covers waking from idle through the pin, where a missing or short-lived RAM write block would expose writes from the resumed core. Requests raised while reset is held would wrongly put the core to sleep. An interrupt raised in power-down would wrongly restart the clocks.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WAKE  = 2'd3
  } lpState_t;

  // Strobes from the sequencer to the pin/enable datapath
  typedef struct packed {
    logic cpuRun;
    logic perRun;
    logic oscRun;
    logic pinHold;
    logic holdHigh;
    logic blockSet;
    logic blockClr;
  } lpStrobe_t;

endpackage

// File: rtl/lp_rst_qual.sv
module lp_rst_qual #(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MCS     = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic rstPin,
  input  logic qualEn,
  output logic sysRst
);
  localparam int RST_LEN = CLKS_PER_MC * RST_MCS;
  localparam int CNT_W   = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] highCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      highCnt <= '0;
    end else if (!qualEn || !rstPin) begin
      highCnt <= '0;
    end else if (highCnt != CNT_W'(RST_LEN)) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign sysRst = (highCnt == CNT_W'(RST_LEN));

  // R5: a low sample removes reset at the following edge
  p_low_drops_reset_r5: assert property (@(posedge clk) disable iff (!porN)
    !rstPin |=> !sysRst);

  // R5: reset only appears after a high sample
  p_rise_after_high_r5: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRst) |-> $past(rstPin));

  // R9: no filtering while the oscillator is not stable
  p_no_count_unstable_r9: assert property (@(posedge clk) disable iff (!porN)
    !qualEn |=> !sysRst);

endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_pkg::*;
#(
  parameter int STAB_CYCLES = 64
) (
  input  logic      clk,
  input  logic      porN,
  input  logic      rstPin,
  input  logic      idleReq,
  input  logic      pdReq,
  input  logic      irqPending,
  input  logic      sysRst,
  output logic      qualEn,
  output lpStrobe_t strobes
);
  lpState_t state, stateNxt;
  logic     stabDone;

  generate
    if (STAB_CYCLES == 0) begin : g_noStab
      assign stabDone = 1'b1;
    end else begin : g_stab
      localparam int STAB_W = $clog2(STAB_CYCLES + 1);
      logic [STAB_W-1:0] stabCnt;

      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          stabCnt <= '0;
        end else if (state != ST_WAKE) begin
          stabCnt <= '0;
        end else if (stabCnt != STAB_W'(STAB_CYCLES)) begin
          stabCnt <= stabCnt + 1'b1;
        end
      end

      assign stabDone = (stabCnt == STAB_W'(STAB_CYCLES));
    end
  endgenerate

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN: begin
        if (!sysRst) begin
          if (pdReq)        stateNxt = ST_PDOWN;
          else if (idleReq) stateNxt = ST_IDLE;
        end
      end
      ST_IDLE:  if (rstPin || irqPending) stateNxt = ST_RUN;
      ST_PDOWN: if (rstPin)               stateNxt = ST_WAKE;
      ST_WAKE: begin
        if (!rstPin)     stateNxt = ST_PDOWN;
        else if (sysRst) stateNxt = ST_RUN;
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  assign qualEn = (state == ST_RUN) || (state == ST_IDLE) ||
                  ((state == ST_WAKE) && stabDone);

  always_comb begin
    strobes.cpuRun   = (state == ST_RUN);
    strobes.perRun   = (state == ST_RUN) || (state == ST_IDLE);
    strobes.oscRun   = (state != ST_PDOWN);
    strobes.pinHold  = (state != ST_RUN);
    strobes.holdHigh = (state == ST_IDLE);
    strobes.blockSet = (state == ST_IDLE) && rstPin;
    strobes.blockClr = !rstPin;
  end

  // R3: a pending interrupt ends idle at the next edge
  p_idle_irq_wake_r3: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_IDLE) && irqPending |=> (state == ST_RUN));

  // R4: power-down is held without a reset pin sample
  p_pd_needs_pin_r4: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_PDOWN) && !rstPin |=> (state == ST_PDOWN));

  // R9: the core cannot resume before the settling count
  p_no_early_run_r9: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_WAKE) && !stabDone |=> (state != ST_RUN));

  // R10: requests are ignored while reset is in control
  p_req_in_reset_r10: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN) && sysRst |=> (state == ST_RUN));

endmodule

// File: rtl/lp_datapath.sv
module lp_datapath
  import lp_pkg::*;
(
  input  logic      clk,
  input  logic      porN,
  input  lpStrobe_t strobes,
  input  logic      extExec,
  output logic      cpuClkEn,
  output logic      perClkEn,
  output logic      oscEn,
  output logic      pinOvrEn,
  output logic      aleLevel,
  output logic      psenLevel,
  output logic      p0Float,
  output logic      ramWrBlock
);
  logic blockFlag;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 blockFlag <= 1'b0;
    else if (strobes.blockSet) blockFlag <= 1'b1;
    else if (strobes.blockClr) blockFlag <= 1'b0;
  end

  assign cpuClkEn   = strobes.cpuRun;
  assign perClkEn   = strobes.perRun;
  assign oscEn      = strobes.oscRun;
  assign pinOvrEn   = strobes.pinHold;
  assign aleLevel   = strobes.pinHold && strobes.holdHigh;
  assign psenLevel  = strobes.pinHold && strobes.holdHigh;
  assign p0Float    = strobes.pinHold && extExec;
  assign ramWrBlock = blockFlag;

  // R8: the block persists while the pin stays high
  p_block_holds_r8: assert property (@(posedge clk) disable iff (!porN)
    ramWrBlock && !strobes.blockClr |=> ramWrBlock);

  // R7: the port is never released for internal execution
  p_float_ext_only_r7: assert property (@(posedge clk) disable iff (!porN)
    p0Float |-> extExec);

  // R6: raised strobe levels only while the CPU clock is stopped
  p_levels_asleep_r6: assert property (@(posedge clk) disable iff (!porN)
    (aleLevel || psenLevel) |-> (pinOvrEn && !cpuClkEn));

endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl
  import lp_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int RST_MCS     = 2,
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic porN,
  input  logic rstPin,
  input  logic idleReq,
  input  logic pdReq,
  input  logic irqPending,
  input  logic extExec,
  output logic cpuClkEn,
  output logic perClkEn,
  output logic oscEn,
  output logic pinOvrEn,
  output logic aleLevel,
  output logic psenLevel,
  output logic p0Float,
  output logic sysRst,
  output logic ramWrBlock
);
  lpStrobe_t strobes;
  logic      qualEn;

  lp_rst_qual #(.CLKS_PER_MC(CLKS_PER_MC), .RST_MCS(RST_MCS)) i_qual (
    .clk(clk), .porN(porN), .rstPin(rstPin), .qualEn(qualEn), .sysRst(sysRst)
  );

  lp_ctrl #(.STAB_CYCLES(STAB_CYCLES)) i_ctrl (
    .clk(clk), .porN(porN), .rstPin(rstPin), .idleReq(idleReq), .pdReq(pdReq),
    .irqPending(irqPending), .sysRst(sysRst), .qualEn(qualEn), .strobes(strobes)
  );

  lp_datapath i_dp (
    .clk(clk), .porN(porN), .strobes(strobes), .extExec(extExec),
    .cpuClkEn(cpuClkEn), .perClkEn(perClkEn), .oscEn(oscEn),
    .pinOvrEn(pinOvrEn), .aleLevel(aleLevel), .psenLevel(psenLevel),
    .p0Float(p0Float), .ramWrBlock(ramWrBlock)
  );

endmodule

// File: tb/test_lp_power_ctrl.sv
module test_lp_power_ctrl;
  localparam int MC   = 12;
  localparam int MCS  = 2;
  localparam int STAB = 40;
  localparam int RL   = MC * MCS;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstPin = 1'b0, idleReq = 1'b0, pdReq = 1'b0, irqPending = 1'b0, extExec = 1'b0;
  logic cpuClkEn, perClkEn, oscEn, pinOvrEn, aleLevel, psenLevel, p0Float, sysRst, ramWrBlock;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lp_power_ctrl #(.CLKS_PER_MC(MC), .RST_MCS(MCS), .STAB_CYCLES(STAB)) i_lp_power_ctrl (
    .clk(clk), .porN(porN), .rstPin(rstPin), .idleReq(idleReq), .pdReq(pdReq),
    .irqPending(irqPending), .extExec(extExec), .cpuClkEn(cpuClkEn),
    .perClkEn(perClkEn), .oscEn(oscEn), .pinOvrEn(pinOvrEn), .aleLevel(aleLevel),
    .psenLevel(psenLevel), .p0Float(p0Float), .sysRst(sysRst), .ramWrBlock(ramWrBlock)
  );

  // Behavioural reference: 0 running, 1 idle, 2 power-down, 3 oscillator restart
  int mMode = 0, mHigh = 0, mStab = 0, nMode;
  bit mBlock = 0, stable, inReset;

  always @(posedge clk) begin
    if (!porN) begin
      mMode = 0; mHigh = 0; mStab = 0; mBlock = 0;
    end else begin
      stable  = (mMode <= 1) || (mMode == 3 && mStab >= STAB);
      inReset = (mHigh >= RL);
      nMode = mMode;
      case (mMode)
        0: if (!inReset) begin
             if (pdReq) nMode = 2;
             else if (idleReq) nMode = 1;
           end
        1: if (rstPin || irqPending) nMode = 0;
        2: if (rstPin) nMode = 3;
        default: if (!rstPin) nMode = 2; else if (inReset) nMode = 0;
      endcase
      if (mMode == 1 && rstPin) mBlock = 1;
      else if (!rstPin) mBlock = 0;
      mStab = (mMode == 3) ? mStab + 1 : 0;
      mHigh = (stable && rstPin) ? mHigh + 1 : 0;
      mMode = nMode;
    end
  end

  task automatic check1(string name, string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, name, act, exp, $time);
    end
  endtask

  // Compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (porN && !finished) begin
      check1("cpuClkEn",   "R2", cpuClkEn,   mMode == 0);
      check1("perClkEn",   "R2", perClkEn,   mMode <= 1);
      check1("oscEn",      "R4", oscEn,      mMode != 2);
      check1("pinOvrEn",   "R6", pinOvrEn,   mMode != 0);
      check1("aleLevel",   "R6", aleLevel,   mMode == 1);
      check1("psenLevel",  "R6", psenLevel,  mMode == 1);
      check1("p0Float",    "R7", p0Float,    extExec && mMode != 0);
      check1("sysRst",     "R5", sysRst,     mHigh >= RL);
      check1("ramWrBlock", "R8", ramWrBlock, mBlock);
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    tick(2);
    porN = 1'b1;
    tick(4);                                   // R1: reset state
    irqPending = 1'b1; tick(3); irqPending = 1'b0;   // R3: ignored while running
    idleReq = 1'b1; tick(1); idleReq = 1'b0;   // R2: enter idle
    tick(5);
    extExec = 1'b1; tick(3);                   // R7: float with external fetch
    irqPending = 1'b1; tick(1); irqPending = 1'b0;   // R3: wake by interrupt
    tick(3);
    idleReq = 1'b1; pdReq = 1'b1; tick(1); idleReq = 1'b0; pdReq = 1'b0; // R2: priority
    tick(4);
    irqPending = 1'b1; tick(4); irqPending = 1'b0;   // R4: no effect in power-down
    extExec = 1'b0; tick(2);                   // R6, R7 power-down levels
    rstPin = 1'b1; tick(10); rstPin = 1'b0;    // R9: aborted restart
    tick(4);
    rstPin = 1'b1; tick(1 + STAB + RL + 6);    // R9, R5: full wake and reset
    idleReq = 1'b1; tick(2); idleReq = 1'b0;   // R10: ignored during reset
    rstPin = 1'b0; tick(4);
    rstPin = 1'b1; tick(RL - 1); rstPin = 1'b0; // R5: one short of the count
    tick(3);
    rstPin = 1'b1; tick(RL + 2); rstPin = 1'b0; // R5: exact count
    tick(3);
    extExec = 1'b1;
    idleReq = 1'b1; tick(1); idleReq = 1'b0;   // R6: idle levels
    tick(3);
    rstPin = 1'b1; tick(RL + 4);               // R8: idle left by pin, RAM blocked
    pdReq = 1'b1; tick(1); pdReq = 1'b0;       // R10 again
    rstPin = 1'b0; tick(5);
    summary();
  end
endmodule